// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives an active-low system reset for the rest of a chip. It takes two requests. One is a supply-low flag from an external comparator, active high. The other is a manual reset pin, active low. While either request is present the reset output stays low. Once both requests are gone, the block holds the reset low for a further fixed number of cycles of its free-running clock and then releases it. If a new request arrives before that stretch ends, the count is discarded. A later clear then starts a complete new stretch.

Both requests pass through two-flop synchronizers before they are used. The manual pin also goes through a width filter, so a low pulse shorter than a set number of clock cycles has no effect. A status output reports when the release countdown is running. An asynchronous power-on clear puts the block in the held-reset state with its counter at zero.

Top module: `supv_reset_gen`

## Requirements
- R1: While `por_clr` is high, `sys_rst_n` is 0 and `tmr_busy` is 0. This takes effect at once, without waiting for a clock edge.
- R2: Suppose `supply_low` goes high and stays high. By the third rising clock edge after it goes high, `sys_rst_n` is 0. From then on `sys_rst_n` stays 0 and `tmr_busy` stays 0 for as long as `supply_low` stays high.
- R3: Suppose `supply_low` falls while the manual request is inactive. Then `tmr_busy` is high for exactly `REL_CYC` consecutive cycles, and `sys_rst_n` rises on the (`REL_CYC`+3)-th rising edge after the fall.
- R4: Suppose `supply_low` is high at any rising edge while the countdown runs. Then the count is discarded and `sys_rst_n` never rises during that countdown. After `supply_low` falls again, a complete new countdown of `REL_CYC` busy cycles follows, and the release comes on the (`REL_CYC`+3)-th edge.
- R5: Suppose `man_rst_n` is held low for at least `MR_MIN_CYC` rising edges. Then `sys_rst_n` goes to 0, and for as long as the pin stays low the countdown is held cleared (`tmr_busy` = 0).
- R6: Suppose `man_rst_n` is low for fewer than `MR_MIN_CYC` rising edges while the reset is released. Then `sys_rst_n` stays 1 and `tmr_busy` stays 0.
- R7: After a qualifying manual reset, `man_rst_n` returning high starts a full countdown of `REL_CYC` busy cycles. `sys_rst_n` rises on the (`REL_CYC`+4)-th rising edge after the pin returns high. This holds even if the manual reset interrupted an earlier countdown.
- R8: `tmr_busy` and `sys_rst_n` are never high together, and `sys_rst_n` only rises directly at the end of a countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| por_clr | input | 1 | Asynchronous power-on clear, active high |
| supply_low | input | 1 | Supply-low flag from the comparator, active high |
| man_rst_n | input | 1 | Manual reset pin, active low |
| sys_rst_n | output | 1 | System reset output, active low |
| tmr_busy | output | 1 | High while the release countdown is running |

## Verification
The bench builds the block with `REL_CYC` = 20 and `MR_MIN_CYC` = 4. With these values every individual cycle can be reached in a short run. The bench interrupts the countdown with a one-cycle supply-low pulse at every position from its first to its last cycle. It sweeps the manual pulse width from one edge up to one edge past the filter limit, plus one long hold. For each case it checks the exact release edge and the length of the busy run against values computed from the two parameters.

// File: rtl/supv_rst_pkg.sv
package supv_rst_pkg;

    // Defaults: 200 ms and 150 ns at a 40 MHz oscillator
    localparam int unsigned REL_CYC_DEFAULT = 8_000_000;
    localparam int unsigned MR_MIN_DEFAULT  = 6;

    typedef enum logic [1:0] {
        RS_HOLD  = 2'd0,
        RS_COUNT = 2'd1,
        RS_RUN   = 2'd2
    } rel_state_e;

    typedef struct packed {
        logic supply_low;
        logic man_active;
    } hold_req_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic logic hold_any(input hold_req_t r);
        return r.supply_low | r.man_active;
    endfunction

endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic dout
);
    logic meta;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            meta <= RST_VAL;
            dout <= RST_VAL;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter
    import supv_rst_pkg::*;
#(
    parameter int unsigned MIN_CYC = MR_MIN_DEFAULT
) (
    input  logic clk,
    input  logic clr,
    input  logic pin_n,
    output logic active
);
    localparam int unsigned CW = cnt_width(MIN_CYC);
    localparam logic [CW-1:0] FULL = CW'(MIN_CYC);

    logic [CW-1:0] low_cnt;

    // Saturating count of consecutive low samples; any high sample clears it
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            low_cnt <= '0;
        end else if (pin_n) begin
            low_cnt <= '0;
        end else if (low_cnt != FULL) begin
            low_cnt <= low_cnt + CW'(1);
        end
    end

    assign active = (low_cnt == FULL);
endmodule

// File: rtl/supv_rel_timer.sv
module supv_rel_timer
    import supv_rst_pkg::*;
#(
    parameter int unsigned REL_CYC = REL_CYC_DEFAULT
) (
    input  logic       clk,
    input  logic       clr,
    input  hold_req_t  req,
    output rel_state_e state,
    output logic       busy
);
    localparam int unsigned CW = cnt_width(REL_CYC);
    localparam logic [CW-1:0] LAST = CW'(REL_CYC - 1);

    logic [CW-1:0] cnt;
    rel_state_e    st_q;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st_q <= RS_HOLD;
            cnt  <= '0;
        end else if (hold_any(req)) begin
            st_q <= RS_HOLD;
            cnt  <= '0;
        end else begin
            case (st_q)
                RS_HOLD: begin
                    st_q <= RS_COUNT;
                    cnt  <= '0;
                end
                RS_COUNT: begin
                    if (cnt == LAST) begin
                        st_q <= RS_RUN;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RS_RUN: begin
                    st_q <= RS_RUN;
                end
                default: begin
                    st_q <= RS_HOLD;
                    cnt  <= '0;
                end
            endcase
        end
    end

    assign state = st_q;
    assign busy  = (st_q == RS_COUNT);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_rst_pkg::*;
#(
    parameter int unsigned REL_CYC    = REL_CYC_DEFAULT,
    parameter int unsigned MR_MIN_CYC = MR_MIN_DEFAULT
) (
    input  logic clk,
    input  logic por_clr,
    input  logic supply_low,
    input  logic man_rst_n,
    output logic sys_rst_n,
    output logic tmr_busy
);
    logic       sl_sync;
    logic       mr_sync_n;
    logic       mr_active;
    hold_req_t  req;
    rel_state_e rel_state;

    // Supply flag clears to "low supply" so the output stays held after clear
    supv_sync2 #(.RST_VAL(1'b1)) u_sl_sync (
        .clk  (clk),
        .clr  (por_clr),
        .din  (supply_low),
        .dout (sl_sync)
    );

    supv_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
        .clk  (clk),
        .clr  (por_clr),
        .din  (man_rst_n),
        .dout (mr_sync_n)
    );

    supv_mr_filter #(.MIN_CYC(MR_MIN_CYC)) u_mr_filter (
        .clk    (clk),
        .clr    (por_clr),
        .pin_n  (mr_sync_n),
        .active (mr_active)
    );

    assign req.supply_low = sl_sync;
    assign req.man_active = mr_active;

    supv_rel_timer #(.REL_CYC(REL_CYC)) u_rel_timer (
        .clk   (clk),
        .clr   (por_clr),
        .req   (req),
        .state (rel_state),
        .busy  (tmr_busy)
    );

    assign sys_rst_n = (rel_state == RS_RUN);
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int unsigned REL_CYC = 20
) (
    input logic clk,
    input logic por_clr,
    input logic supply_low,
    input logic sys_rst_n,
    input logic tmr_busy,
    input logic man_active
);
    logic [31:0] busy_run;

    always_ff @(posedge clk or posedge por_clr) begin
        if (por_clr) begin
            busy_run <= '0;
        end else if (tmr_busy) begin
            busy_run <= busy_run + 32'd1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (por_clr)
        (supply_low && $past(supply_low) && $past(supply_low, 2)) |=> (!sys_rst_n && !tmr_busy)); // R2

    AST_RESTART_ON_SUPPLY: assert property (@(posedge clk) disable iff (por_clr)
        (tmr_busy && supply_low && $past(supply_low) && $past(supply_low, 2)) |=> !tmr_busy); // R4

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (por_clr)
        tmr_busy |-> !sys_rst_n); // R8

    AST_RELEASE_FROM_COUNT: assert property (@(posedge clk) disable iff (por_clr)
        $rose(sys_rst_n) |-> $past(tmr_busy)); // R8

    AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (por_clr)
        man_active |=> (!sys_rst_n && !tmr_busy)); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (por_clr)
        tmr_busy |-> (busy_run < REL_CYC)); // R3
endmodule

bind supv_reset_gen supv_reset_chk #(.REL_CYC(REL_CYC)) u_chk (
    .clk        (clk),
    .por_clr    (por_clr),
    .supply_low (supply_low),
    .sys_rst_n  (sys_rst_n),
    .tmr_busy   (tmr_busy),
    .man_active (mr_active)
);

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REL  = 20;
    localparam int MINW = 4;

    logic clk = 1'b0;
    logic por_clr;
    logic supply_low;
    logic man_rst_n;
    logic sys_rst_n;
    logic tmr_busy;

    int checks = 0;
    int fails  = 0;
    int excl_viol = 0;
    bit done = 1'b0;

    supv_reset_gen #(.REL_CYC(REL), .MR_MIN_CYC(MINW)) u_supv_reset_gen (
        .clk        (clk),
        .por_clr    (por_clr),
        .supply_low (supply_low),
        .man_rst_n  (man_rst_n),
        .sys_rst_n  (sys_rst_n),
        .tmr_busy   (tmr_busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (tmr_busy && sys_rst_n) excl_viol++;
    endtask

    // Counts edges until release; run is the length of the last busy stretch
    task automatic wait_release(output int n, output int run);
        bit seen_low;
        n = 0;
        run = 0;
        seen_low = !sys_rst_n;
        while (n < REL * 4) begin
            tick();
            n++;
            if (!sys_rst_n) seen_low = 1'b1;
            if (tmr_busy) run++;
            else if (!sys_rst_n) run = 0;
            if (seen_low && sys_rst_n) break;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int run;
        int bad;

        por_clr = 1'b1;
        supply_low = 1'b0;
        man_rst_n = 1'b1;
        #3;
        chk(!sys_rst_n && !tmr_busy, "R1 clear state", {sys_rst_n, tmr_busy}, 0);
        repeat (3) @(negedge clk);
        por_clr = 1'b0;
        wait_release(n, run);
        chk(run == REL, "R3 countdown after clear", run, REL);

        // R3: plain brownout and recovery
        supply_low = 1'b1;
        repeat (5) tick();
        supply_low = 1'b0;
        wait_release(n, run);
        chk(n == REL + 3, "R3 release edge", n, REL + 3);
        chk(run == REL, "R3 busy length", run, REL);

        // R2: assertion latency and hold while flag stays high
        supply_low = 1'b1;
        repeat (3) tick();
        chk(!sys_rst_n, "R2 asserted by third edge", sys_rst_n, 0);
        bad = 0;
        repeat (40) begin
            tick();
            if (sys_rst_n || tmr_busy) bad++;
        end
        chk(bad == 0, "R2 held while flag high", bad, 0);
        supply_low = 1'b0;
        wait_release(n, run);
        chk(n == REL + 3, "R2 release after hold", n, REL + 3);

        // R4: one-cycle brownout at every point of the countdown
        for (int k = 1; k <= REL; k++) begin
            supply_low = 1'b1;
            repeat (4) tick();
            supply_low = 1'b0;
            bad = 0;
            repeat (k) begin
                tick();
                if (sys_rst_n) bad++;
            end
            supply_low = 1'b1;
            tick();
            if (sys_rst_n) bad++;
            supply_low = 1'b0;
            wait_release(n, run);
            chk(bad == 0 && n == REL + 3, "R4 restart release edge", n + 1000 * bad, REL + 3);
            chk(run == REL, "R4 full fresh countdown", run, REL);
        end

        // R5/R6/R7: manual pulse width sweep from released state
        for (int w = 1; w <= MINW + 2; w++) begin
            int len;
            len = (w == MINW + 2) ? MINW + 10 : w;
            man_rst_n = 1'b0;
            repeat (len) tick();
            if (len >= MINW + 3)
                chk(!sys_rst_n && !tmr_busy, "R5 held during long manual", {sys_rst_n, tmr_busy}, 0);
            man_rst_n = 1'b1;
            if (len < MINW) begin
                bad = 0;
                repeat (MINW + 8) begin
                    tick();
                    if (!sys_rst_n || tmr_busy) bad++;
                end
                chk(bad == 0, "R6 short manual pulse ignored", bad, 0);
            end else begin
                wait_release(n, run);
                chk(n == REL + 4, "R7 manual release edge", n, REL + 4);
                chk(run == REL, "R7 manual full countdown", run, REL);
            end
        end

        // R5/R7: manual reset interrupting a running countdown
        supply_low = 1'b1;
        repeat (4) tick();
        supply_low = 1'b0;
        repeat (10) tick();
        man_rst_n = 1'b0;
        repeat (MINW + 10) tick();
        chk(!tmr_busy && !sys_rst_n, "R5 manual clears countdown", {sys_rst_n, tmr_busy}, 0);
        man_rst_n = 1'b1;
        wait_release(n, run);
        chk(n == REL + 4, "R7 release after interrupted count", n, REL + 4);
        chk(run == REL, "R7 count restarted from zero", run, REL);

        // R1: asynchronous clear while released
        repeat (2) tick();
        #(CLK_PERIOD / 4);
        por_clr = 1'b1;
        #1;
        chk(!sys_rst_n && !tmr_busy, "R1 async clear mid-run", {sys_rst_n, tmr_busy}, 0);
        @(negedge clk);
        por_clr = 1'b0;
        wait_release(n, run);
        chk(run == REL, "R1 counter zero after clear", run, REL);

        chk(excl_viol == 0, "R8 busy and release exclusive", excl_viol, 0);
        finish_run();
    end
endmodule